// File: doc/BRIEF.md
# Aspect-Configurable Dual-Port RAM

This block holds 256 bits of storage behind one write port and one read port. Each port has its own clock. A static parameter sets, for each port, whether it acts on the rising or the falling edge of that clock. A run-time mode input sets the shape of the array. In byte mode it is 32 words of 8 bits. In nibble mode it is 64 words of 4 bits. Both shapes use the same physical rows, so data written in one mode can be read back in the other.

Each port has its own enable. A shared block enable gates both ports, so several instances can sit side by side to make a wider word, or be selected by upper address decode to make a deeper memory. Address, data and control are sampled on each port's active edge. The read result is held in an output register that changes only on an enabled read.

Top module: `aspect_dpram`

## Requirements
- R1: While `rst` is high at an active read edge, `rd_data` is cleared to zero, and it reads zero on the first active read edge after reset is released.
- R2: In byte mode (`byte_mode`=1), an enabled write stores `wr_data[7:0]` in row `wr_addr[4:0]`. Address bit 5 is ignored on both ports, and an enabled read returns the whole byte of row `rd_addr[4:0]`.
- R3: In nibble mode (`byte_mode`=0), an enabled write puts `wr_data[3:0]` into row `wr_addr[4:0]`. It goes in bits 3:0 when `wr_addr[5]`=0 and in bits 7:4 when `wr_addr[5]`=1. The other nibble of that row keeps its value.
- R4: In nibble mode, an enabled read places the nibble chosen by `rd_addr[5]` (same lane rule as R3) on `rd_data[3:0]` and drives `rd_data[7:4]` to zero.
- R5: A write takes place on the active write edge only when `wr_en` and `blk_en` are both 1. Otherwise no stored bit changes.
- R6: `rd_data` is updated on the active read edge only when `rd_en` and `blk_en` are both 1. Otherwise it holds its previous value.
- R7: When one active edge both reads and writes the same location, the read returns the contents from before that write. This holds in both modes.
- R8: With the polarity parameter of a port set to 1, that port acts on the falling edge of its clock. With the parameter set to 0, it acts on the rising edge.
- R9: The stored rows do not depend on the mode. Row `r` read in nibble mode gives its low nibble at `{0,r}` and its high nibble at `{1,r}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| rd_clk | input | 1 | Read port clock |
| rst | input | 1 | Synchronous active-high reset of the read output register |
| byte_mode | input | 1 | 1 = 32x8 organisation, 0 = 64x4 organisation |
| blk_en | input | 1 | Block enable shared by both ports |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 8 | Write data (only bits 3:0 used in nibble mode) |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 6 | Read word address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds two instances with the default 6-bit address and 8-bit data. Both instances take the same stimulus. The first uses rising-edge ports. The second uses falling-edge ports on inverted clocks, so both must produce identical results, and this exercises each polarity variant of the clock stage. The two clocks share one phase, so the bench can make a read and a write land on the same row on the same edge. This covers the read-before-write rule and the nibble lane masks under the same mode changes.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  // Array organisation selected by the mode pin
  typedef enum logic {
    ORG_NIBBLE = 1'b0,
    ORG_BYTE   = 1'b1
  } org_e;
endpackage

// File: rtl/dpram_clk_pol.sv
module dpram_clk_pol #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk_in,
  output logic clk_out
);
  // Static polarity choice: the downstream logic always uses posedge
  generate
    if (FALLING) begin : g_inv
      assign clk_out = ~clk_in;
    end else begin : g_pass
      assign clk_out = clk_in;
    end
  endgenerate
endmodule

// File: rtl/dpram_addr_map.sv
module dpram_addr_map
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int ROW_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  org_e              org,
  output logic [ROW_W-1:0]  row,
  output logic              hi_lane
);
  // Low bits pick the physical row in either organisation; the top bit
  // picks the nibble lane only when the array is nibble-wide.
  assign row     = addr[ROW_W-1:0];
  assign hi_lane = (org == ORG_NIBBLE) && addr[ADDR_W-1];
endmodule

// File: rtl/dpram_store.sv
module dpram_store
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int ROW_W = ADDR_W - 1,
  localparam int DEPTH = 1 << ROW_W,
  localparam int HALF  = DATA_W / 2
) (
  input  logic              wck,
  input  logic              rck,
  input  logic              rst,
  input  org_e              org,
  input  logic              wr_fire,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              rd_fire,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic              rd_hi,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wr_mask;
  logic [DATA_W-1:0] rd_sel;
  logic [DATA_W-1:0] rd_next;

  // Lane mask: whole row in byte mode, one half in nibble mode
  always_comb begin
    if (org == ORG_BYTE)
      wr_mask = '1;
    else if (wr_hi)
      wr_mask = {{HALF{1'b1}}, {HALF{1'b0}}};
    else
      wr_mask = {{HALF{1'b0}}, {HALF{1'b1}}};
  end

  always_ff @(posedge wck) begin
    if (wr_fire)
      mem[wr_row] <= (mem[wr_row] & ~wr_mask) | (wr_word & wr_mask);
  end

  assign rd_sel = mem[rd_row];

  always_comb begin
    if (org == ORG_BYTE)
      rd_next = rd_sel;
    else if (rd_hi)
      rd_next = {{HALF{1'b0}}, rd_sel[DATA_W-1:HALF]};
    else
      rd_next = {{HALF{1'b0}}, rd_sel[HALF-1:0]};
  end

  always_ff @(posedge rck) begin
    if (rst)
      rd_q <= '0;
    else if (rd_fire)
      rd_q <= rd_next;
  end

  // R2
  byte_wr_chk: assert property (@(posedge wck) disable iff (rst)
    (wr_fire && org == ORG_BYTE) |=> (mem[$past(wr_row)] === $past(wr_word)));

  // R3
  nib_keep_chk: assert property (@(posedge wck) disable iff (rst)
    (wr_fire && org == ORG_NIBBLE) |=>
      ((mem[$past(wr_row)] & ~$past(wr_mask)) === ($past(mem[wr_row]) & ~$past(wr_mask))));

  // R5
  idle_wr_chk: assert property (@(posedge wck) disable iff (rst)
    !wr_fire |=> (mem[$past(wr_row)] === $past(mem[wr_row])));

  // R1
  rst_clear_chk: assert property (@(posedge rck) disable iff (rst)
    $fell(rst) |-> (rd_q == '0));

  // R4
  nib_rd_chk: assert property (@(posedge rck) disable iff (rst)
    (rd_fire && org == ORG_NIBBLE) |=> (rd_q[DATA_W-1:HALF] == '0));

  // R6
  rd_hold_chk: assert property (@(posedge rck) disable iff (rst)
    !rd_fire |=> $stable(rd_q));
endmodule

// File: rtl/aspect_dpram.sv
module aspect_dpram
  import dpram_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter bit WR_CLK_FALL = 1'b0,
  parameter bit RD_CLK_FALL = 1'b0
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              byte_mode,
  input  logic              blk_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ROW_W = ADDR_W - 1;
  localparam int HALF  = DATA_W / 2;

  logic             wck, rck;
  org_e             org;
  logic [ROW_W-1:0] wr_row, rd_row;
  logic             wr_hi, rd_hi;
  logic [DATA_W-1:0] wr_word;

  assign org = org_e'(byte_mode);

  // Nibble data is replicated into both lanes; the lane mask picks one
  assign wr_word = (org == ORG_BYTE) ? wr_data : {2{wr_data[HALF-1:0]}};

  dpram_clk_pol #(.FALLING(WR_CLK_FALL)) u_wpol (.clk_in(wr_clk), .clk_out(wck));
  dpram_clk_pol #(.FALLING(RD_CLK_FALL)) u_rpol (.clk_in(rd_clk), .clk_out(rck));

  dpram_addr_map #(.ADDR_W(ADDR_W)) u_wmap (
    .addr(wr_addr), .org(org), .row(wr_row), .hi_lane(wr_hi));
  dpram_addr_map #(.ADDR_W(ADDR_W)) u_rmap (
    .addr(rd_addr), .org(org), .row(rd_row), .hi_lane(rd_hi));

  dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .wck     (wck),
    .rck     (rck),
    .rst     (rst),
    .org     (org),
    .wr_fire (wr_en && blk_en),
    .wr_row  (wr_row),
    .wr_hi   (wr_hi),
    .wr_word (wr_word),
    .rd_fire (rd_en && blk_en),
    .rd_row  (rd_row),
    .rd_hi   (rd_hi),
    .rd_q    (rd_data)
  );
endmodule

// File: tb/aspect_dpram_tb_top.sv
module aspect_dpram_tb_top;
  logic clk = 1'b0;
  logic clk_n;
  logic rst = 1'b1;
  logic byte_mode = 1'b1, blk_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_p, rd_n;
  logic [7:0] model [32];
  logic [7:0] exp_rd = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  assign clk_n = ~clk;

  aspect_dpram dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst(rst), .byte_mode(byte_mode), .blk_en(blk_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_p));

  // R8: falling-edge ports on inverted clocks must track dut_i exactly
  aspect_dpram #(.WR_CLK_FALL(1'b1), .RD_CLK_FALL(1'b1)) dut_neg (
    .wr_clk(clk_n), .rd_clk(clk_n), .rst(rst), .byte_mode(byte_mode), .blk_en(blk_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_n));

  function automatic logic [7:0] ref_read(logic mode, logic [5:0] a);
    if (mode) return model[a[4:0]];
    return a[5] ? {4'h0, model[a[4:0]][7:4]} : {4'h0, model[a[4:0]][3:0]};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Apply current inputs for one edge; reference reads before it writes (R7)
  task automatic cycle();
    if (rst) exp_rd = 8'h00;
    else if (rd_en && blk_en) exp_rd = ref_read(byte_mode, rd_addr);
    if (wr_en && blk_en) begin
      if (byte_mode) model[wr_addr[4:0]] = wr_data;
      else if (wr_addr[5]) model[wr_addr[4:0]][7:4] = wr_data[3:0];
      else model[wr_addr[4:0]][3:0] = wr_data[3:0];
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req);
    check(req, rd_p, exp_rd);
    check("R8", rd_n, exp_rd);
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; blk_en = 1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    cycle(); cycle();
    chk("R1");
    rst = 0; idle();
    cycle();
    chk("R1");

    // R2: fill in byte mode with bit 5 set (ignored)
    byte_mode = 1; wr_en = 1;
    for (int i = 0; i < 32; i++) begin
      wr_addr = {1'b1, 5'(i)}; wr_data = 8'($urandom);
      cycle();
    end
    wr_en = 0; rd_en = 1;
    for (int i = 0; i < 32; i++) begin
      rd_addr = {1'($urandom), 5'(i)};
      cycle(); chk("R2");
    end

    // R9 / R4: same rows read as nibbles
    byte_mode = 0;
    for (int i = 0; i < 64; i++) begin
      rd_addr = 6'(i);
      cycle(); chk("R9"); check("R4", rd_p & 8'hF0, 8'h00);
    end

    // R3: nibble write to high lane, junk in upper data bits
    wr_en = 1; rd_en = 0; wr_addr = 6'h23; wr_data = 8'hA5; cycle();
    wr_addr = 6'h04; wr_data = 8'h7C; cycle();
    wr_en = 0; rd_en = 1; byte_mode = 1;
    rd_addr = 6'h03; cycle(); chk("R3");
    rd_addr = 6'h04; cycle(); chk("R3");

    // R5: gated writes
    wr_en = 1; blk_en = 0; wr_addr = 6'h05; wr_data = 8'hEE; cycle();
    wr_en = 0; blk_en = 1; wr_data = 8'h11; cycle();
    rd_en = 1; rd_addr = 6'h05; cycle(); chk("R5");

    // R6: hold when not enabled
    rd_en = 0; rd_addr = 6'h06; cycle(); chk("R6");
    rd_en = 1; blk_en = 0; rd_addr = 6'h07; cycle(); chk("R6");
    blk_en = 1;

    // R7: same-location collision in both modes
    byte_mode = 1; wr_en = 1; rd_en = 1; wr_addr = 6'h09; rd_addr = 6'h29; wr_data = 8'h3C;
    cycle(); chk("R7");
    wr_en = 0; cycle(); chk("R7");
    byte_mode = 0; wr_en = 1; wr_addr = 6'h29; rd_addr = 6'h29; wr_data = 8'h0F;
    cycle(); chk("R7");
    wr_en = 0; cycle(); chk("R7");

    // Random mix with frequent collisions
    for (int i = 0; i < 3000; i++) begin
      byte_mode = 1'($urandom);
      blk_en = ($urandom % 8) != 0;
      wr_en = 1'($urandom); rd_en = 1'($urandom);
      wr_addr = 6'($urandom); wr_data = 8'($urandom);
      rd_addr = (($urandom % 4) == 0) ? wr_addr : 6'($urandom);
      cycle();
      chk(byte_mode ? "R2" : "R4");
    end

    // R1 again mid-run
    rst = 1; idle(); cycle(); chk("R1");
    rst = 0; cycle(); chk("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule